// File: doc/BRIEF.md
# Four-Register Signed Calculator Datapath

This block is a small signed arithmetic engine that keeps a bank of four 16-bit registers. Each clock cycle it takes one command: it picks two registers as operands using a one-bit-per-register source mask, then adds them, subtracts them or compares them. The result of an addition or subtraction is written back on the rising edge into every register whose bit is set in a destination mask. An averaging mode halves the full-precision sum or difference before the write-back.

Two status outputs report on the previous cycle's command. An equality flag pulses when a compare finds matching operands. An error flag rises for signed overflow and for malformed commands. A separate load port presets any register, and a synchronous reset clears the bank. The add and subtract path runs through a ripple-carry adder that is one bit wider than the operands.

Top module: `calc4_core`

## Requirements
- R1: While `rst` is high at a rising edge, all four registers become zero and both `err_flag` and `eq_flag` become low.
- R2: A command with only `op_add` high and exactly two `src_sel` bits set writes A+B. A is the register with the lower selected index and B is the register with the higher one. Operands are signed two's complement.
- R3: A command with only `op_sub` high writes A−B, with A and B chosen in the same order as for addition.
- R4: With `avg_mode` high, an add or subtract forms the 17-bit signed sum or difference and shifts it arithmetically right by one, which rounds toward minus infinity. That value is written and `err_flag` stays low.
- R5: A plain add or subtract whose true result lies outside −32768..32767 raises `err_flag` and writes no register.
- R6: A command with only `op_eq` high writes no register and keeps `err_flag` low. It raises `eq_flag` for that one cycle exactly when the two operands are equal. `avg_mode` has no effect on a compare.
- R7: A cycle without a load is malformed if the number of op lines set is not exactly one, or if the number of `src_sel` bits set is not exactly two. A malformed cycle raises `err_flag`, keeps `eq_flag` low and writes no register.
- R8: A successful add or subtract writes every register whose `dst_sel` bit is set, possibly several at once. If `dst_sel` is zero, nothing is written.
- R9: When `ld_en` is high, `ld_data` is written into register `ld_idx` and every op line is ignored. The register bank changes only at that index, and both flags go low.
- R10: Register i appears on `regs_out[16*i+15:16*i]`. `err_flag` and `eq_flag` are registered, so each reports the command from the edge just before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_add | input | 1 | Request addition |
| op_sub | input | 1 | Request subtraction |
| op_eq | input | 1 | Request equality compare |
| avg_mode | input | 1 | Halve sum or difference before write-back |
| src_sel | input | 4 | Operand mask, one bit per register |
| dst_sel | input | 4 | Destination mask, one bit per register |
| ld_en | input | 1 | Preset one register this cycle |
| ld_idx | input | 2 | Register index for preset |
| ld_data | input | 16 | Preset value |
| regs_out | output | 64 | All register contents, register i at bits 16i+15..16i |
| eq_flag | output | 1 | Operands of previous compare were equal |
| err_flag | output | 1 | Previous command overflowed or was malformed |

## Verification
A wrong operand order shows up only on subtraction, so the sub cases use registers with different values. Such an error changes the destination register one edge after the command. A corrupted carry chain or overflow detector shows up either as a missing `err_flag` pulse or as a wrapped value written at that same edge. Averaging cases with negative odd results expose a missing sign extension or a wrong rounding, again in the very next register readout. Malformed and overflowing commands are followed by a full bank comparison, so a stray write is visible one cycle after it happens.

// File: rtl/calc4_pkg.sv
package calc4_pkg;

  typedef enum logic [1:0] {
    OPK_ADD = 2'd0,
    OPK_SUB = 2'd1,
    OPK_EQ  = 2'd2,
    OPK_BAD = 2'd3
  } op_kind_t;

  // Exactly one request line picks an operation; anything else is malformed.
  function automatic op_kind_t decode_op(input logic a, input logic s, input logic e);
    op_kind_t k;
    case ({a, s, e})
      3'b100:  k = OPK_ADD;
      3'b010:  k = OPK_SUB;
      3'b001:  k = OPK_EQ;
      default: k = OPK_BAD;
    endcase
    return k;
  endfunction

  // Signed overflow of a (W+1)-bit result formed from sign-extended operands:
  // the two top bits disagree.
  function automatic logic top_bits_differ(input logic hi, input logic lo);
    return hi ^ lo;
  endfunction

endpackage

// File: rtl/calc4_ripple.sv
module calc4_ripple #(
  parameter int W = 17
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W-1:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i] = a[i] ^ b[i] ^ carry[i];
    if (i < W - 1) begin : g_c
      assign carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
    end
  end
endmodule

// File: rtl/calc4_opsel.sv
module calc4_opsel #(
  parameter int N = 4
) (
  input  logic [N-1:0]         src_sel,
  output logic [$clog2(N)-1:0] idx_a,
  output logic [$clog2(N)-1:0] idx_b,
  output logic                 pair_ok
);
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt;
  logic          seen;

  always_comb begin
    cnt   = '0;
    idx_a = '0;
    idx_b = '0;
    seen  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (src_sel[i]) begin
        cnt = cnt + CW'(1);
        if (!seen) begin
          idx_a = IW'(i);
          seen  = 1'b1;
        end
        idx_b = IW'(i);
      end
    end
    pair_ok = (cnt == CW'(2));
  end
endmodule

// File: rtl/calc4_alu.sv
module calc4_alu
  import calc4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         is_sub,
  input  logic         avg,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         same
);
  localparam int XW = W + 1;

  logic [XW-1:0] a_ext;
  logic [XW-1:0] b_ext;
  logic [XW-1:0] b_eff;
  logic [XW-1:0] wide;

  assign a_ext = {opa[W-1], opa};
  assign b_ext = {opb[W-1], opb};
  assign b_eff = is_sub ? ~b_ext : b_ext;

  calc4_ripple #(.W(XW)) u_ripple (
    .a   (a_ext),
    .b   (b_eff),
    .cin (is_sub),
    .sum (wide)
  );

  assign ovf    = top_bits_differ(wide[XW-1], wide[XW-2]);
  assign result = avg ? wide[XW-1:1] : wide[W-1:0];
  assign same   = (opa == opb);
endmodule

// File: rtl/calc4_regfile.sv
module calc4_regfile #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_en,
  input  logic [$clog2(N)-1:0] ld_idx,
  input  logic [W-1:0]         ld_data,
  input  logic [N-1:0]         wr_en,
  input  logic [W-1:0]         wr_data,
  output logic [W*N-1:0]       regs_flat
);
  localparam int IW = $clog2(N);

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (ld_en && (ld_idx == IW'(i)))
        q <= ld_data;
      else if (wr_en[i])
        q <= wr_data;
    end
    assign regs_flat[i*W +: W] = q;
  end
endmodule

// File: rtl/calc4_core.sv
module calc4_core
  import calc4_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_add,
  input  logic                 op_sub,
  input  logic                 op_eq,
  input  logic                 avg_mode,
  input  logic [N-1:0]         src_sel,
  input  logic [N-1:0]         dst_sel,
  input  logic                 ld_en,
  input  logic [$clog2(N)-1:0] ld_idx,
  input  logic [W-1:0]         ld_data,
  output logic [W*N-1:0]       regs_out,
  output logic                 eq_flag,
  output logic                 err_flag
);
  localparam int IW = $clog2(N);

  op_kind_t      kind;
  logic [IW-1:0] idx_a;
  logic [IW-1:0] idx_b;
  logic          pair_ok;
  logic [W-1:0]  opa;
  logic [W-1:0]  opb;
  logic [W-1:0]  alu_res;
  logic          alu_ovf;
  logic          alu_same;
  logic          is_arith;
  logic          cmd_bad;
  logic          ovf_hit;
  logic          wr_fire;
  logic [N-1:0]  wr_en;
  logic          err_d;
  logic          eq_d;

  assign kind = decode_op(op_add, op_sub, op_eq);

  calc4_opsel #(.N(N)) u_opsel (
    .src_sel (src_sel),
    .idx_a   (idx_a),
    .idx_b   (idx_b),
    .pair_ok (pair_ok)
  );

  assign opa = regs_out[int'(idx_a)*W +: W];
  assign opb = regs_out[int'(idx_b)*W +: W];

  calc4_alu #(.W(W)) u_alu (
    .opa    (opa),
    .opb    (opb),
    .is_sub (kind == OPK_SUB),
    .avg    (avg_mode),
    .result (alu_res),
    .ovf    (alu_ovf),
    .same   (alu_same)
  );

  // Named internal events, visible to the bound checker.
  assign is_arith = (kind == OPK_ADD) || (kind == OPK_SUB);
  assign cmd_bad  = (kind == OPK_BAD) || !pair_ok;
  assign ovf_hit  = !cmd_bad && is_arith && !avg_mode && alu_ovf;
  assign wr_fire  = !ld_en && !cmd_bad && is_arith && !ovf_hit;
  assign wr_en    = dst_sel & {N{wr_fire}};
  assign err_d    = !ld_en && (cmd_bad || ovf_hit);
  assign eq_d     = !ld_en && !cmd_bad && (kind == OPK_EQ) && alu_same;

  calc4_regfile #(.W(W), .N(N)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (ld_en),
    .ld_idx    (ld_idx),
    .ld_data   (ld_data),
    .wr_en     (wr_en),
    .wr_data   (alu_res),
    .regs_flat (regs_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      eq_flag  <= 1'b0;
    end else begin
      err_flag <= err_d;
      eq_flag  <= eq_d;
    end
  end
endmodule

// File: rtl/calc4_checker.sv
module calc4_checker #(
  parameter int W = 16,
  parameter int N = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ld_en,
  input logic [$clog2(N)-1:0] ld_idx,
  input logic [W-1:0]         ld_data,
  input logic [W*N-1:0]       regs_out,
  input logic                 eq_flag,
  input logic                 err_flag,
  input logic                 cmd_bad
);
  // R1: reset leaves a cleared bank and quiet flags
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs_out == '0) && !err_flag && !eq_flag);

  // R5 and R7: a reported error never comes with a register change
  a_r5_no_write_on_err: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !$past(rst)) |-> (regs_out == $past(regs_out)));

  // R6: a compare hit leaves the bank untouched and reports no error
  a_r6_eq_quiet: assert property (@(posedge clk) disable iff (rst)
    (eq_flag && !$past(rst)) |-> (regs_out == $past(regs_out)) && !err_flag);

  // R7: a malformed command without a load is always reported
  a_r7_bad_flagged: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_bad) && !$past(ld_en) && !$past(rst)) |-> err_flag);

  // R9: a load lands at its index and silences both flags
  a_r9_load_lands: assert property (@(posedge clk) disable iff (rst)
    ($past(ld_en) && !$past(rst)) |->
      (regs_out[int'($past(ld_idx))*W +: W] == $past(ld_data)) && !err_flag && !eq_flag);
endmodule

bind calc4_core calc4_checker #(.W(W), .N(N)) u_calc4_checker (
  .clk      (clk),
  .rst      (rst),
  .ld_en    (ld_en),
  .ld_idx   (ld_idx),
  .ld_data  (ld_data),
  .regs_out (regs_out),
  .eq_flag  (eq_flag),
  .err_flag (err_flag),
  .cmd_bad  (cmd_bad)
);

// File: tb/calc4_core_bench.sv
module calc4_core_bench;
  localparam int W = 16;
  localparam int N = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic           op_add = 0, op_sub = 0, op_eq = 0, avg_mode = 0;
  logic [N-1:0]   src_sel = '0, dst_sel = '0;
  logic           ld_en = 0;
  logic [1:0]     ld_idx = '0;
  logic [W-1:0]   ld_data = '0;
  logic [W*N-1:0] regs_out;
  logic           eq_flag, err_flag;

  calc4_core #(.W(W), .N(N)) u_calc4_core (
    .clk(clk), .rst(rst), .op_add(op_add), .op_sub(op_sub), .op_eq(op_eq),
    .avg_mode(avg_mode), .src_sel(src_sel), .dst_sel(dst_sel), .ld_en(ld_en),
    .ld_idx(ld_idx), .ld_data(ld_data), .regs_out(regs_out),
    .eq_flag(eq_flag), .err_flag(err_flag)
  );

  typedef struct {
    logic [W*N-1:0] regs;
    logic           err;
    logic           eq;
    string          tag;
  } exp_t;

  exp_t q[$];
  logic signed [W-1:0] m [N];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [W*N-1:0] pack_model();
    logic [W*N-1:0] p;
    for (int i = 0; i < N; i++) p[i*W +: W] = m[i];
    return p;
  endfunction

  task automatic push_exp(input logic e, input logic qf, input string tag);
    exp_t x;
    x.regs = pack_model();
    x.err  = e;
    x.eq   = qf;
    x.tag  = tag;
    q.push_back(x);
  endtask

  // Driver: one command per cycle, expected outcome computed from the requirements.
  task automatic cmd(input logic a, input logic s, input logic e, input logic v,
                     input logic [N-1:0] src, input logic [N-1:0] dst, input string tag);
    int ia, ib, nsrc, nop;
    longint sa, sb, r;
    logic xe, xq;
    @(negedge clk);
    op_add = a; op_sub = s; op_eq = e; avg_mode = v;
    src_sel = src; dst_sel = dst; ld_en = 0;
    nop = int'(a) + int'(s) + int'(e);
    nsrc = 0; ia = -1; ib = -1;
    for (int i = 0; i < N; i++) if (src[i]) begin
      nsrc++;
      if (ia < 0) ia = i; else ib = i;
    end
    xe = 0; xq = 0;
    if (nop != 1 || nsrc != 2) xe = 1;
    else begin
      sa = longint'(m[ia]);
      sb = longint'(m[ib]);
      if (e) xq = (sa == sb);
      else begin
        r = s ? sa - sb : sa + sb;
        if (v) r = r >>> 1;
        if (!v && (r > 32767 || r < -32768)) xe = 1;
        else for (int i = 0; i < N; i++) if (dst[i]) m[i] = r[W-1:0];
      end
    end
    @(posedge clk); #1;
    push_exp(xe, xq, tag);
  endtask

  task automatic load(input int idx, input logic [W-1:0] d, input logic noise, input string tag);
    @(negedge clk);
    ld_en = 1; ld_idx = idx[1:0]; ld_data = d;
    op_add = noise; op_sub = noise; op_eq = 0; avg_mode = 0;
    src_sel = noise ? 4'b0011 : 4'b0000; dst_sel = noise ? 4'b1111 : 4'b0000;
    m[idx] = d;
    @(posedge clk); #1;
    push_exp(0, 0, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1; ld_en = 0;
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) m[i] = '0;
    push_exp(0, 0, tag);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic chk(input logic [W*N-1:0] act, input logic [W*N-1:0] exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares each expected item half a cycle after its edge.
  initial begin : mon
    exp_t x;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        x = q.pop_front();
        chk(regs_out, x.regs, "regs", x.tag);
        chk({63'b0, err_flag}, {63'b0, x.err}, "err_flag", x.tag);
        chk({63'b0, eq_flag}, {63'b0, x.eq}, "eq_flag", x.tag);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < N; i++) m[i] = '0;
    repeat (2) @(posedge clk);
    #1 push_exp(0, 0, "R1 reset state");
    @(negedge clk); rst = 0;

    load(0, 16'd100, 0, "R9 load r0");
    load(1, 16'hFFF9, 0, "R9 load r1");
    load(2, 16'h7FFF, 0, "R9 load r2");
    load(3, 16'd5, 1, "R9 load with ops ignored");
    load(3, 16'h1234, 0, "R10 layout r3");
    load(3, 16'd5, 0, "R9 reload r3");

    cmd(1, 0, 0, 0, 4'b0011, 4'b1000, "R2 add r0+r1");
    cmd(0, 1, 0, 0, 4'b0011, 4'b1000, "R3 sub r0-r1");
    cmd(0, 1, 0, 0, 4'b1001, 4'b0010, "R3 sub order r0-r3");
    cmd(1, 0, 0, 0, 4'b1100, 4'b0001, "R5 add overflow");
    cmd(1, 0, 0, 1, 4'b1100, 4'b0001, "R4 avg add no overflow");
    load(1, 16'hFFF9, 0, "R9 load r1 again");
    cmd(0, 1, 0, 1, 4'b0011, 4'b0100, "R4 avg sub");
    load(0, 16'hFFF0, 0, "R9 load r0 neg");
    cmd(1, 0, 0, 1, 4'b0011, 4'b1000, "R4 avg negative odd");
    load(0, 16'h8000, 0, "R9 load min");
    load(1, 16'd1, 0, "R9 load one");
    cmd(0, 1, 0, 0, 4'b0011, 4'b0100, "R5 sub underflow");
    cmd(0, 1, 0, 1, 4'b0011, 4'b0100, "R4 avg sub at min");
    load(2, 16'd1, 0, "R9 load r2 match");
    cmd(0, 0, 1, 0, 4'b0110, 4'b1111, "R6 equal match");
    cmd(0, 0, 1, 1, 4'b0011, 4'b1111, "R6 equal mismatch with avg");
    cmd(1, 1, 0, 0, 4'b0011, 4'b1111, "R7 two op lines");
    cmd(0, 0, 0, 0, 4'b0011, 4'b1111, "R7 no op line");
    cmd(1, 0, 0, 0, 4'b0111, 4'b1111, "R7 three sources");
    cmd(1, 0, 0, 0, 4'b0100, 4'b1111, "R7 one source");
    cmd(1, 0, 0, 0, 4'b0110, 4'b1011, "R8 multi destination");
    cmd(1, 0, 0, 0, 4'b0011, 4'b0000, "R8 no destination");
    do_reset("R1 reset clears bank");
    cmd(0, 0, 1, 0, 4'b1010, 4'b0000, "R6 equal after reset");

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule